// File: doc/BRIEF.md
# Paged PHY Register Window Bridge

This block is a register-bus slave that lets a host reach a large register space spread over several PHY devices through a small memory window. The host first writes a sticky map register, which selects one PHY device and one page of that device's 16-bit register space. Each word slot of the window then stands for one register of that page. A host read or write to a slot becomes a single transaction on an internal PHY register bus. That transaction carries the device ID and the full register address, which the bridge builds from the map's page bits and the slot number.

The host side is a simple valid/ready register bus. The host holds `host_valid` with its address and data until the bridge returns a one-cycle `host_ready` pulse with read data and an error flag. The PHY side is a request/acknowledge bus. The bridge keeps `phy_req` and its fields steady until `phy_ack`. It handles one transaction at a time, so the map value and the window access that uses it are always issued together as one unit.

Top module: `phy_window_bridge`

## Requirements
- R1: The map register is reached at byte address 0x800 and resets to zero. A map write stores host write-data bits [11:0] and drops the rest. A map read returns the stored 12 bits with the upper 20 bits zero.
- R2: In the map value, bits [11:7] give the 5-bit PHY device ID and bits [6:0] give the page, which is register-address bits [15:9].
- R3: A host access at byte address 0x000 to 0x7FF issues one PHY transaction. It uses `phy_dev` = map device ID and `phy_addr` = {page, host_addr[10:2]}. Byte-address bits [1:0] are ignored.
- R4: A window write issues `phy_we`=1 with `phy_wdata` equal to host write-data bits [15:0]. A window read issues `phy_we`=0.
- R5: A window read returns {16'h0000, phy_rdata}. Window writes and map writes return read data zero.
- R6: `host_ready` stays low while a PHY transaction is open. It pulses for exactly one cycle, in the cycle after the one in which `phy_ack` is high with `phy_req`. After a map or error access, the pulse comes one cycle after the request is taken.
- R7: Host byte addresses 0x804 to 0xFFF give `host_err`=1 with `host_ready`. They issue no PHY transaction and leave the map register unchanged.
- R8: `phy_req`, `phy_we`, `phy_dev`, `phy_addr` and `phy_wdata` hold steady from issue until acknowledged. Each window access uses the map value in force when that access is taken.
- R9: `host_err` is zero for map and window accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request valid, held until host_ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Decode error, valid with host_ready |
| host_rdata | output | 32 | Read data, valid with host_ready |
| phy_req | output | 1 | PHY transaction request |
| phy_we | output | 1 | PHY transaction is a write |
| phy_dev | output | 5 | Target PHY device ID |
| phy_addr | output | 16 | Full PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | PHY transaction acknowledge |
| phy_rdata | input | 16 | PHY read data, valid with phy_ack |

## Verification
The map register is loaded with mixed bit patterns, all-ones and all-zeros. This shows that each device and page bit lands in its own field, and that map bits 12 to 31 are dropped. Window accesses reach the first slot, the last slot, slots with non-zero low address bits, and a spread of slots, with acknowledge latencies from zero to several cycles. This shows whether slot bits reach the right register-address bits, and whether completion waits for the acknowledge. A read after a map change, at an offset used earlier, shows that each access takes the current map value. Addresses just past the map register and at the top of the space show that the decode error path touches neither the PHY bus nor the map.

// File: rtl/phywin_pkg.sv
package phywin_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_RESP = 2'd2
   } phywin_state_e;

   typedef enum logic [1:0] {
      HIT_WIN  = 2'd0,
      HIT_MAP  = 2'd1,
      HIT_NONE = 2'd2
   } phywin_hit_e;
endpackage

// File: rtl/phywin_decode.sv
module phywin_decode
   import phywin_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int OFF_W  = 9
) (
   input  logic [ADDR_W-1:0] addr,
   output phywin_hit_e       hit,
   output logic [OFF_W-1:0]  slot
);
   localparam int SEL_BIT = OFF_W + 2;

   logic upper_zero;
   logic unused_byte_bits;

   generate
      if (ADDR_W > SEL_BIT + 1) begin : g_upper
         assign upper_zero = ~|addr[ADDR_W-1:SEL_BIT+1];
      end else begin : g_no_upper
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign unused_byte_bits = ^addr[1:0];
   assign slot = addr[SEL_BIT-1:2];

   always_comb begin
      hit = HIT_NONE;
      if (upper_zero && !addr[SEL_BIT])
         hit = HIT_WIN;
      else if (upper_zero && addr[SEL_BIT] && (slot == '0))
         hit = HIT_MAP;
   end
endmodule

// File: rtl/phywin_map.sv
module phywin_map #(
   parameter int DEV_W  = 5,
   parameter int PAGE_W = 7,
   localparam int MAP_W = DEV_W + PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [MAP_W-1:0]  wdata,
   output logic [MAP_W-1:0]  map_q,
   output logic [DEV_W-1:0]  dev,
   output logic [PAGE_W-1:0] page
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         map_q <= '0;
      else if (we)
         map_q <= wdata;
   end

   assign dev  = map_q[MAP_W-1:PAGE_W];
   assign page = map_q[PAGE_W-1:0];
endmodule

// File: rtl/phywin_seq.sv
module phywin_seq
   import phywin_pkg::*;
#(
   parameter int HOST_DW = 32,
   parameter int DEV_W   = 5,
   parameter int PAGE_W  = 7,
   parameter int OFF_W   = 9,
   parameter int PHY_DW  = 16,
   localparam int MAP_W  = DEV_W + PAGE_W,
   localparam int PHY_AW = PAGE_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_valid,
   input  logic               host_write,
   input  phywin_hit_e        hit,
   input  logic [OFF_W-1:0]   slot,
   input  logic [PHY_DW-1:0]  wdata,
   input  logic [MAP_W-1:0]   map_q,
   input  logic [DEV_W-1:0]   dev,
   input  logic [PAGE_W-1:0]  page,
   output logic               map_we,
   output logic               host_ready,
   output logic               host_err,
   output logic [HOST_DW-1:0] host_rdata,
   output logic               phy_req,
   output logic               phy_we,
   output logic [DEV_W-1:0]   phy_dev,
   output logic [PHY_AW-1:0]  phy_addr,
   output logic [PHY_DW-1:0]  phy_wdata,
   input  logic               phy_ack,
   input  logic [PHY_DW-1:0]  phy_rdata
);
   phywin_state_e st;
   logic take;

   assign take   = (st == ST_IDLE) && host_valid;
   assign map_we = take && (hit == HIT_MAP) && host_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         host_ready <= 1'b0;
         host_err   <= 1'b0;
         host_rdata <= '0;
         phy_we     <= 1'b0;
         phy_dev    <= '0;
         phy_addr   <= '0;
         phy_wdata  <= '0;
      end else begin
         host_ready <= 1'b0;
         host_err   <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (host_valid) begin
                  case (hit)
                     HIT_WIN: begin
                        st        <= ST_BUSY;
                        phy_we    <= host_write;
                        phy_dev   <= dev;
                        phy_addr  <= {page, slot};
                        phy_wdata <= host_write ? wdata : '0;
                     end
                     HIT_MAP: begin
                        st         <= ST_RESP;
                        host_ready <= 1'b1;
                        host_rdata <= host_write ? '0 : HOST_DW'(map_q);
                     end
                     default: begin
                        st         <= ST_RESP;
                        host_ready <= 1'b1;
                        host_err   <= 1'b1;
                        host_rdata <= '0;
                     end
                  endcase
               end
            end
            ST_BUSY: begin
               if (phy_ack) begin
                  st         <= ST_RESP;
                  host_ready <= 1'b1;
                  host_rdata <= phy_we ? '0 : HOST_DW'(phy_rdata);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign phy_req = (st == ST_BUSY);
endmodule

// File: rtl/phy_window_bridge.sv
module phy_window_bridge
   import phywin_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int HOST_DW = 32,
   parameter int DEV_W   = 5,
   parameter int PAGE_W  = 7,
   parameter int OFF_W   = 9,
   parameter int PHY_DW  = 16,
   localparam int MAP_W  = DEV_W + PAGE_W,
   localparam int PHY_AW = PAGE_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_valid,
   input  logic               host_write,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic [HOST_DW-1:0] host_wdata,
   output logic               host_ready,
   output logic               host_err,
   output logic [HOST_DW-1:0] host_rdata,
   output logic               phy_req,
   output logic               phy_we,
   output logic [DEV_W-1:0]   phy_dev,
   output logic [PHY_AW-1:0]  phy_addr,
   output logic [PHY_DW-1:0]  phy_wdata,
   input  logic               phy_ack,
   input  logic [PHY_DW-1:0]  phy_rdata
);
   generate
      if (ADDR_W < OFF_W + 3) begin : g_bad_addr
         $error("ADDR_W too small for window plus map register");
      end
      if (PHY_DW > HOST_DW) begin : g_bad_dw
         $error("PHY_DW must not exceed HOST_DW");
      end
      if (MAP_W > HOST_DW) begin : g_bad_map
         $error("map register wider than host data");
      end
   endgenerate

   phywin_hit_e        hit;
   logic [OFF_W-1:0]   slot;
   logic               map_we;
   logic [MAP_W-1:0]   map_q;
   logic [DEV_W-1:0]   dev;
   logic [PAGE_W-1:0]  page;
   logic               unused_wdata;

   generate
      if (HOST_DW > PHY_DW && HOST_DW > MAP_W) begin : g_unused
         assign unused_wdata = ^host_wdata[HOST_DW-1:(PHY_DW > MAP_W ? PHY_DW : MAP_W)];
      end else begin : g_all_used
         assign unused_wdata = 1'b0;
      end
   endgenerate

   phywin_decode #(
      .ADDR_W(ADDR_W),
      .OFF_W (OFF_W)
   ) u_decode (
      .addr(host_addr),
      .hit (hit),
      .slot(slot)
   );

   phywin_map #(
      .DEV_W (DEV_W),
      .PAGE_W(PAGE_W)
   ) u_map (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (map_we),
      .wdata(host_wdata[MAP_W-1:0]),
      .map_q(map_q),
      .dev  (dev),
      .page (page)
   );

   phywin_seq #(
      .HOST_DW(HOST_DW),
      .DEV_W  (DEV_W),
      .PAGE_W (PAGE_W),
      .OFF_W  (OFF_W),
      .PHY_DW (PHY_DW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_valid(host_valid),
      .host_write(host_write),
      .hit       (hit),
      .slot      (slot),
      .wdata     (host_wdata[PHY_DW-1:0]),
      .map_q     (map_q),
      .dev       (dev),
      .page      (page),
      .map_we    (map_we),
      .host_ready(host_ready),
      .host_err  (host_err),
      .host_rdata(host_rdata),
      .phy_req   (phy_req),
      .phy_we    (phy_we),
      .phy_dev   (phy_dev),
      .phy_addr  (phy_addr),
      .phy_wdata (phy_wdata),
      .phy_ack   (phy_ack),
      .phy_rdata (phy_rdata)
   );
endmodule

// File: rtl/phywin_bridge_chk.sv
module phywin_bridge_chk #(
   parameter int HOST_DW = 32,
   parameter int DEV_W   = 5,
   parameter int PAGE_W  = 7,
   parameter int OFF_W   = 9,
   parameter int PHY_DW  = 16,
   localparam int PHY_AW = PAGE_W + OFF_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               host_ready,
   input logic               host_err,
   input logic [HOST_DW-1:0] host_rdata,
   input logic               phy_req,
   input logic               phy_ack,
   input logic               phy_we,
   input logic [DEV_W-1:0]   phy_dev,
   input logic [PHY_AW-1:0]  phy_addr,
   input logic [PHY_DW-1:0]  phy_wdata
);
   // R6
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |=> !host_ready);

   // R6
   ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req && phy_ack) |=> (host_ready && !phy_req));

   // R6
   no_ready_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(phy_req && host_ready));

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr) && $stable(phy_dev)
                                 && $stable(phy_we) && $stable(phy_wdata)));

   // R7
   err_only_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_err |-> host_ready);

   // R5
   rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> (host_rdata[HOST_DW-1:PHY_DW] == '0));
endmodule

bind phy_window_bridge phywin_bridge_chk #(
   .HOST_DW(HOST_DW),
   .DEV_W  (DEV_W),
   .PAGE_W (PAGE_W),
   .OFF_W  (OFF_W),
   .PHY_DW (PHY_DW)
) u_chk (.*);

// File: tb/phy_window_bridge_test.sv
`timescale 1ns/100ps
module phy_window_bridge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_valid = 1'b0;
   logic        host_write = 1'b0;
   logic [11:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic        host_ready;
   logic        host_err;
   logic [31:0] host_rdata;
   logic        phy_req;
   logic        phy_we;
   logic [4:0]  phy_dev;
   logic [15:0] phy_addr;
   logic [15:0] phy_wdata;
   logic        phy_ack = 1'b0;
   logic [15:0] phy_rdata = '0;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int ack_cyc = 0;
   int lat = 0;
   bit done = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   phy_window_bridge uut (.*);

   typedef struct {
      logic [31:0] rdata;
      logic        err;
      logic        phy;
      string       tag;
   } resp_t;

   typedef struct {
      logic        we;
      logic [4:0]  dev;
      logic [15:0] addr;
      logic [15:0] wdata;
      string       tag;
   } preq_t;

   resp_t rq[$];
   preq_t pq[$];
   logic [15:0] mem [logic [20:0]];
   logic [11:0] bmap = '0;

   function automatic logic [15:0] peek(logic [20:0] k);
      if (mem.exists(k)) return mem[k];
      return k[15:0] ^ 16'hA5C3;
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // PHY register-array model
   bit    in_req = 0;
   int    wait_cnt = 0;
   preq_t cur;
   always @(negedge clk) begin
      phy_ack = 1'b0;
      if (rst_n && phy_req) begin
         if (!in_req) begin
            in_req = 1;
            wait_cnt = 0;
            if (pq.size() == 0) begin
               check(0, "R7 unexpected PHY request", {16'h0, phy_addr}, 32'h0);
               cur = '{we: phy_we, dev: phy_dev, addr: phy_addr, wdata: phy_wdata, tag: "R7"};
            end else begin
               cur = pq.pop_front();
               check(phy_addr == cur.addr, {cur.tag, " R3 phy_addr"}, {16'h0, phy_addr}, {16'h0, cur.addr});
               check(phy_dev == cur.dev, {cur.tag, " R2 phy_dev"}, {27'h0, phy_dev}, {27'h0, cur.dev});
               check(phy_we == cur.we, {cur.tag, " R4 phy_we"}, {31'h0, phy_we}, {31'h0, cur.we});
               if (cur.we)
                  check(phy_wdata == cur.wdata, {cur.tag, " R4 phy_wdata"}, {16'h0, phy_wdata}, {16'h0, cur.wdata});
            end
         end else if (phy_addr != cur.addr || phy_dev != cur.dev || phy_we != cur.we) begin
            check(0, "R8 request changed before ack", {16'h0, phy_addr}, {16'h0, cur.addr});
         end
         if (wait_cnt >= lat) begin
            phy_ack = 1'b1;
            if (phy_we) mem[{phy_dev, phy_addr}] = phy_wdata;
            else phy_rdata = peek({phy_dev, phy_addr});
            ack_cyc = cyc;
            in_req = 0;
         end else begin
            wait_cnt++;
         end
      end
   end

   // response monitor
   always @(negedge clk) begin
      if (rst_n && host_ready) begin
         if (rq.size() == 0) begin
            check(0, "R6 unexpected host_ready", host_rdata, 32'h0);
         end else begin
            resp_t e;
            e = rq.pop_front();
            check(host_rdata == e.rdata, {e.tag, " rdata"}, host_rdata, e.rdata);
            check(host_err == e.err, {e.tag, " R9 err flag"}, {31'h0, host_err}, {31'h0, e.err});
            if (e.phy)
               check(cyc == ack_cyc + 1, {e.tag, " R6 ready timing"}, cyc, ack_cyc + 1);
         end
      end
   end

   task automatic access(bit w, logic [11:0] a, logic [31:0] d, string tag);
      resp_t r;
      r.tag = tag;
      r.err = 0;
      r.phy = 0;
      r.rdata = '0;
      if (a < 12'h800) begin
         logic [15:0] ra;
         ra = {bmap[6:0], a[10:2]};
         pq.push_back('{we: w, dev: bmap[11:7], addr: ra, wdata: d[15:0], tag: tag});
         r.phy = 1;
         if (!w) r.rdata = {16'h0, peek({bmap[11:7], ra})};
      end else if (a[11:2] == 10'h200) begin
         if (w) bmap = d[11:0];
         else r.rdata = {20'h0, bmap};
      end else begin
         r.err = 1;
      end
      rq.push_back(r);
      @(negedge clk);
      host_valid = 1'b1;
      host_write = w;
      host_addr = a;
      host_wdata = d;
      do @(negedge clk); while (!host_ready);
      host_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 reset state
      check(host_ready == 0 && host_err == 0, "R6 reset outputs", {31'h0, host_ready}, 32'h0);
      check(phy_req == 0, "R3 reset phy_req", {31'h0, phy_req}, 32'h0);
      // R1 reset value and field masking
      access(0, 12'h800, 0, "R1 map reset");
      access(1, 12'h800, 32'hFFFF_F5A3, "R1 map write");
      access(0, 12'h800, 0, "R1 map readback");
      access(0, 12'h802, 0, "R1 map low bits ignored");
      // R3 R4 R5 basic window
      lat = 0;
      access(1, 12'h010, 32'hDEAD_1234, "R4 window write");
      access(0, 12'h010, 0, "R5 window read");
      access(0, 12'h013, 0, "R3 byte bits ignored");
      lat = 6;
      access(0, 12'h7FC, 0, "R6 last slot slow ack");
      access(0, 12'h000, 0, "R3 first slot");
      // R2 extremes of the map fields
      access(1, 12'h800, 32'h0000_0FFF, "R2 map all ones");
      lat = 2;
      access(1, 12'h004, 32'h0000_BEEF, "R2 write dev 31 page 127");
      access(0, 12'h004, 0, "R2 read dev 31 page 127");
      access(1, 12'h800, 32'hFFFF_F000, "R2 map all zeros");
      access(0, 12'h004, 0, "R8 same offset new map");
      // R8 map change between paired accesses
      access(1, 12'h800, 32'h0000_0281, "R8 map A");
      access(1, 12'h100, 32'h0000_1111, "R8 write via A");
      access(1, 12'h800, 32'h0000_0301, "R8 map B");
      access(0, 12'h100, 0, "R8 read via B");
      access(1, 12'h800, 32'h0000_0281, "R8 map A again");
      access(0, 12'h100, 0, "R8 read via A");
      // R7 decode errors, map unchanged
      access(0, 12'h804, 0, "R7 read past map");
      access(1, 12'hFFC, 32'h0000_0ABC, "R7 write top");
      access(1, 12'h900, 32'h0000_0555, "R7 write mid");
      access(0, 12'h800, 0, "R7 map unchanged");
      // spread of slots and latencies
      for (int i = 0; i < 8; i++) begin
         lat = i % 4;
         access(1, 12'((i * 37 % 512) << 2), 32'h5A00_0000 | 32'(i * 4099), "R4 sweep write");
      end
      for (int i = 0; i < 8; i++) begin
         lat = (i + 1) % 5;
         access(0, 12'((i * 37 % 512) << 2), 0, "R5 sweep read");
      end
      repeat (4) @(negedge clk);
      check(rq.size() == 0 && pq.size() == 0, "R6 all responses seen",
            32'(rq.size()), 32'h0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule